// File: doc/BRIEF.md
# Vector Lane Extract Unit

This unit takes one 128-bit vector operand and returns a single integer element from it, chosen by a lane index held in the low bits of an 8-bit immediate. The element may be a byte, a 32-bit word or a 64-bit word. The value is returned zero-extended in a 64-bit result. A width code tells the write-back stage how many result bits to commit. For a memory destination that is exactly the element width. For a register destination it is either a 32-bit or a 64-bit register write.

The unit also checks the encoding fields it is given. A nonzero vector-length field, an unused register field other than all ones, or the reserved size code each raise an undefined-opcode fault. In that case the result is suppressed. A 64-bit element request made outside 64-bit mode is handled as a 32-bit element extract. The unit never touches arithmetic flags and raises no floating-point exception. All outputs are registered and appear one clock after the input strobe.

Top module: `vx_lane_extract`

## Requirements
- R1: With size code 2'b00 (byte), the lane index is imm[3:0] and out_data = {56'b0, src[8*idx+7 : 8*idx]}.
- R2: With size code 2'b01 (32-bit), the lane index is imm[1:0] and out_data = {32'b0, src[32*idx+31 : 32*idx]}.
- R3: With size code 2'b10 (64-bit) and in_mode64 high, the lane index is imm[0] and out_data = src[64*idx+63 : 64*idx].
- R4: With size code 2'b10 and in_mode64 low, the request behaves exactly as size code 2'b01: index imm[1:0], 32-bit result, and a width code other than 64-bit.
- R5: Immediate bits above the index field of the effective element size have no effect on any output.
- R6: For a register destination (in_dst_mem low), out_width is 2'b10 (64-bit write) when the effective size is 64-bit, or when in_mode64 and in_wide are both high. Otherwise it is 2'b01 (32-bit write). All result bits above the element are zero.
- R7: For a memory destination (in_dst_mem high), out_width gives the effective element width: 2'b00 for 8 bits, 2'b01 for 32 bits, 2'b10 for 64 bits.
- R8: A nonzero in_vl raises out_fault.
- R9: An in_vvvv value other than 4'b1111 raises out_fault.
- R10: Size code 2'b11 is reserved and raises out_fault.
- R11: When out_fault is high, out_data is zero and out_width is 2'b00.
- R12: out_valid is high in exactly the cycle after a cycle with in_valid high. The other outputs are registered in that same cycle.
- R13: A synchronous active-high reset clears out_valid and out_fault.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Request strobe |
| in_src | input | 128 | Source vector |
| in_imm | input | 8 | Immediate carrying the lane index |
| in_size | input | 2 | Element size: 00 byte, 01 32-bit, 10 64-bit, 11 reserved |
| in_dst_mem | input | 1 | 1 = memory destination, 0 = register |
| in_mode64 | input | 1 | Processor is in 64-bit mode |
| in_wide | input | 1 | 64-bit destination register selected |
| in_vl | input | 2 | Vector-length encoding field; must be zero |
| in_vvvv | input | 4 | Unused register field; must be 4'b1111 |
| out_valid | output | 1 | Result valid |
| out_data | output | 64 | Zero-extended element |
| out_width | output | 2 | Write width: 00 8-bit, 01 32-bit, 10 64-bit |
| out_fault | output | 1 | Undefined-opcode fault |

## Verification
The bench sweeps every byte, 32-bit and 64-bit lane with high immediate bits set. A design that decodes too many index bits would then pick the wrong lane or go out of range. Requests for 64-bit elements outside 64-bit mode are checked for the 32-bit result and width. A unit that ignored the mode would return 64 bits from the wrong lane. Register and memory destinations are run under every mode and wide-flag combination to catch a wrong write-width code. Each fault source is tried on its own, and the bench requires zero data from a faulting request. A unit that let a result leak past a fault would fail there.

// File: rtl/vx_pkg.sv
package vx_pkg;

    typedef enum logic [1:0] {
        SZ_BYTE  = 2'b00,
        SZ_DWORD = 2'b01,
        SZ_QWORD = 2'b10,
        SZ_RSVD  = 2'b11
    } elem_size_e;

    typedef enum logic [1:0] {
        WW_8  = 2'b00,
        WW_32 = 2'b01,
        WW_64 = 2'b10
    } wr_width_e;

    localparam logic [3:0] VVVV_UNUSED = 4'b1111;

    typedef struct packed {
        logic      fault;
        wr_width_e width;
        logic [63:0] data;
    } result_t;

    // A 64-bit request outside 64-bit mode falls back to the 32-bit form.
    function automatic elem_size_e eff_size(elem_size_e req, logic mode64);
        if (req == SZ_QWORD && !mode64)
            return SZ_DWORD;
        return req;
    endfunction

endpackage

// File: rtl/vx_lane_select.sv
module vx_lane_select
    import vx_pkg::*;
#(
    parameter int SRC_W = 128,
    parameter int RES_W = 64,
    parameter int IMM_W = 8
) (
    input  logic [SRC_W-1:0] src,
    input  logic [IMM_W-1:0] imm,
    input  elem_size_e       size,
    output logic [RES_W-1:0] value
);
    localparam int NB = SRC_W / 8;
    localparam int ND = SRC_W / 32;
    localparam int NQ = SRC_W / 64;
    localparam int IB = $clog2(NB);
    localparam int ID = $clog2(ND);
    localparam int IQ = (NQ > 1) ? $clog2(NQ) : 1;

    logic [7:0]  b_lane [NB];
    logic [31:0] d_lane [ND];
    logic [63:0] q_lane [NQ];

    genvar g;
    generate
        for (g = 0; g < NB; g++) begin : g_b
            assign b_lane[g] = src[8*g +: 8];
        end
        for (g = 0; g < ND; g++) begin : g_d
            assign d_lane[g] = src[32*g +: 32];
        end
        for (g = 0; g < NQ; g++) begin : g_q
            assign q_lane[g] = src[64*g +: 64];
        end
    endgenerate

    logic [7:0]  b_sel;
    logic [31:0] d_sel;
    logic [63:0] q_sel;

    assign b_sel = b_lane[imm[IB-1:0]];
    assign d_sel = d_lane[imm[ID-1:0]];
    assign q_sel = q_lane[imm[IQ-1:0]];

    always_comb begin
        unique case (size)
            SZ_BYTE:  value = RES_W'(b_sel);
            SZ_DWORD: value = RES_W'(d_sel);
            SZ_QWORD: value = RES_W'(q_sel);
            default:  value = '0;
        endcase
    end
endmodule

// File: rtl/vx_encoding_check.sv
module vx_encoding_check
    import vx_pkg::*;
(
    input  elem_size_e size,
    input  logic [1:0] vl,
    input  logic [3:0] vvvv,
    output logic       fault
);
    logic vl_bad, vvvv_bad, size_bad;

    always_comb begin
        vl_bad   = (vl != 2'b00);
        vvvv_bad = (vvvv != VVVV_UNUSED);
        size_bad = (size == SZ_RSVD);
        fault    = vl_bad | vvvv_bad | size_bad;
    end
endmodule

// File: rtl/vx_width_ctrl.sv
module vx_width_ctrl
    import vx_pkg::*;
(
    input  elem_size_e eff,
    input  logic       dst_mem,
    input  logic       mode64,
    input  logic       wide,
    output wr_width_e  width
);
    always_comb begin
        if (dst_mem) begin
            unique case (eff)
                SZ_BYTE:  width = WW_8;
                SZ_DWORD: width = WW_32;
                SZ_QWORD: width = WW_64;
                default:  width = WW_8;
            endcase
        end else if (eff == SZ_QWORD || (mode64 && wide)) begin
            width = WW_64;
        end else begin
            width = WW_32;
        end
    end
endmodule

// File: rtl/vx_lane_extract.sv
module vx_lane_extract
    import vx_pkg::*;
#(
    parameter int SRC_W = 128,
    parameter int RES_W = 64,
    parameter int IMM_W = 8
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             in_valid,
    input  logic [SRC_W-1:0] in_src,
    input  logic [IMM_W-1:0] in_imm,
    input  logic [1:0]       in_size,
    input  logic             in_dst_mem,
    input  logic             in_mode64,
    input  logic             in_wide,
    input  logic [1:0]       in_vl,
    input  logic [3:0]       in_vvvv,
    output logic             out_valid,
    output logic [RES_W-1:0] out_data,
    output logic [1:0]       out_width,
    output logic             out_fault
);
    elem_size_e req_sz, eff;
    logic [RES_W-1:0] lane_val;
    logic             enc_fault;
    wr_width_e        wr_w;
    result_t          nxt;

    assign req_sz = elem_size_e'(in_size);
    assign eff    = eff_size(req_sz, in_mode64);

    vx_lane_select #(.SRC_W(SRC_W), .RES_W(RES_W), .IMM_W(IMM_W)) u_sel (
        .src(in_src), .imm(in_imm), .size(eff), .value(lane_val)
    );

    vx_encoding_check u_chk (
        .size(req_sz), .vl(in_vl), .vvvv(in_vvvv), .fault(enc_fault)
    );

    vx_width_ctrl u_wid (
        .eff(eff), .dst_mem(in_dst_mem), .mode64(in_mode64),
        .wide(in_wide), .width(wr_w)
    );

    always_comb begin
        nxt.fault = enc_fault;
        nxt.width = enc_fault ? WW_8 : wr_w;
        nxt.data  = enc_fault ? 64'd0 : 64'(lane_val);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            out_valid <= 1'b0;
            out_fault <= 1'b0;
            out_data  <= '0;
            out_width <= 2'b00;
        end else begin
            out_valid <= in_valid;
            if (in_valid) begin
                out_fault <= nxt.fault;
                out_data  <= RES_W'(nxt.data);
                out_width <= nxt.width;
            end
        end
    end

    p_imm_known: assert property (@(posedge clk) disable iff (rst)
        in_valid |-> !$isunknown(in_imm));
    p_byte_upper_zero_r1: assert property (@(posedge clk) disable iff (rst)
        (in_valid && in_size == 2'b00) |=> out_data[RES_W-1:8] == '0);
    p_legacy_qword_r4: assert property (@(posedge clk) disable iff (rst)
        (in_valid && in_size == 2'b10 && !in_mode64) |=>
            (out_data[RES_W-1:32] == '0 && out_width != 2'b10));
    p_vl_fault_r8: assert property (@(posedge clk) disable iff (rst)
        (in_valid && in_vl != 2'b00) |=> (out_valid && out_fault));
    p_vvvv_fault_r9: assert property (@(posedge clk) disable iff (rst)
        (in_valid && in_vvvv != 4'b1111) |=> (out_valid && out_fault));
    p_rsvd_fault_r10: assert property (@(posedge clk) disable iff (rst)
        (in_valid && in_size == 2'b11) |=> out_fault);
    p_fault_quiet_r11: assert property (@(posedge clk) disable iff (rst)
        (out_valid && out_fault) |-> (out_data == '0 && out_width == 2'b00));
    p_valid_follow_r12: assert property (@(posedge clk) disable iff (rst)
        in_valid |=> out_valid);
    p_valid_idle_r12: assert property (@(posedge clk) disable iff (rst)
        !in_valid |=> !out_valid);
    p_reset_clear_r13: assert property (@(posedge clk)
        rst |=> (!out_valid && !out_fault));
endmodule

// File: tb/vx_lane_extract_tb_top.sv
module vx_lane_extract_tb_top;
    localparam time CLK_PERIOD = 10ns;

    logic         clk = 1'b0;
    logic         rst = 1'b1;
    logic         in_valid = 1'b0;
    logic [127:0] in_src = '0;
    logic [7:0]   in_imm = '0;
    logic [1:0]   in_size = '0;
    logic         in_dst_mem = 1'b0;
    logic         in_mode64 = 1'b0;
    logic         in_wide = 1'b0;
    logic [1:0]   in_vl = '0;
    logic [3:0]   in_vvvv = 4'hF;
    logic         out_valid;
    logic [63:0]  out_data;
    logic [1:0]   out_width;
    logic         out_fault;

    int n_tests = 0;
    int n_fail  = 0;

    typedef struct {
        logic [63:0] data;
        logic [1:0]  width;
        logic        fault;
        string       tag;
    } exp_t;
    exp_t sb_q[$];

    always #(CLK_PERIOD/2) clk = ~clk;

    vx_lane_extract dut_i (
        .clk(clk), .rst(rst), .in_valid(in_valid), .in_src(in_src),
        .in_imm(in_imm), .in_size(in_size), .in_dst_mem(in_dst_mem),
        .in_mode64(in_mode64), .in_wide(in_wide), .in_vl(in_vl),
        .in_vvvv(in_vvvv), .out_valid(out_valid), .out_data(out_data),
        .out_width(out_width), .out_fault(out_fault)
    );

    function automatic exp_t model(logic [127:0] s, logic [7:0] im, logic [1:0] sz,
                                   logic mem, logic m64, logic wd,
                                   logic [1:0] vl, logic [3:0] vv, string tag);
        exp_t e;
        logic [1:0] es;
        e.tag = tag;
        e.fault = (vl != 0) || (vv != 4'hF) || (sz == 2'b11);
        es = (sz == 2'b10 && !m64) ? 2'b01 : sz;
        if (e.fault) begin
            e.data = 0; e.width = 2'b00;
        end else begin
            case (es)
                2'b00: e.data = {56'd0, s[(im & 8'd15) * 8 +: 8]};
                2'b01: e.data = {32'd0, s[(im & 8'd3) * 32 +: 32]};
                default: e.data = s[(im & 8'd1) * 64 +: 64];
            endcase
            if (mem) e.width = es;
            else e.width = (es == 2'b10 || (m64 && wd)) ? 2'b10 : 2'b01;
        end
        return e;
    endfunction

    task automatic check(string req, logic [63:0] act, logic [63:0] exp);
        n_tests++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic send(logic [127:0] s, logic [7:0] im, logic [1:0] sz, logic mem,
                        logic m64, logic wd, logic [1:0] vl, logic [3:0] vv, string tag);
        @(negedge clk);
        in_valid = 1'b1; in_src = s; in_imm = im; in_size = sz; in_dst_mem = mem;
        in_mode64 = m64; in_wide = wd; in_vl = vl; in_vvvv = vv;
        sb_q.push_back(model(s, im, sz, mem, m64, wd, vl, vv, tag));
        @(negedge clk);
        in_valid = 1'b0;
    endtask

    // Monitor: samples 1 ns after each rising edge.
    initial begin
        forever begin
            @(posedge clk);
            #1ns;
            if (!rst && out_valid) begin
                if (sb_q.size() == 0) begin
                    check("R12 unexpected valid", 64'd1, 64'd0);
                end else begin
                    exp_t e;
                    e = sb_q.pop_front();
                    check({e.tag, " data"}, out_data, e.data);
                    check({e.tag, " width"}, {62'd0, out_width}, {62'd0, e.width});
                    check({e.tag, " fault"}, {63'd0, out_fault}, {63'd0, e.fault});
                end
            end
        end
    end

    initial begin
        #(CLK_PERIOD * 20000);
        check("watchdog expired", 64'd1, 64'd0);
        $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

    initial begin
        logic [127:0] pat;
        pat = 128'hF0E1D2C3B4A5968778695A4B3C2D1E0F;
        repeat (3) @(negedge clk);
        check("R13 reset valid", {63'd0, out_valid}, 64'd0);
        check("R13 reset fault", {63'd0, out_fault}, 64'd0);
        rst = 1'b0;

        for (int i = 0; i < 16; i++)
            send(pat, 8'(i), 2'b00, 1'b0, 1'b1, 1'b1, 2'b00, 4'hF, "R1 byte reg");
        for (int i = 0; i < 16; i++)
            send(pat, 8'(i) | 8'hA0, 2'b00, 1'b1, 1'b0, 1'b0, 2'b00, 4'hF, "R5 R7 byte mem hi-imm");
        for (int i = 0; i < 8; i++)
            send(~pat, 8'(i) | 8'hFC, 2'b01, i[0], 1'b1, i[1], 2'b00, 4'hF, "R2 R5 dword");
        for (int i = 0; i < 4; i++)
            send(pat ^ {4{32'h13579BDF}}, 8'(i) | 8'h5E, 2'b10, i[1], 1'b1, i[0], 2'b00, 4'hF, "R3 R5 qword");
        for (int i = 0; i < 8; i++)
            send(pat, 8'(i), 2'b10, i[2], 1'b0, i[0], 2'b00, 4'hF, "R4 qword legacy");
        for (int i = 0; i < 8; i++)
            send(pat, 8'h07, 2'(i % 2), 1'b0, i[1], i[2], 2'b00, 4'hF, "R6 reg width");
        for (int i = 0; i < 3; i++)
            send(pat, 8'h01, 2'(i), 1'b1, 1'b1, 1'b1, 2'b00, 4'hF, "R7 mem width");
        for (int i = 1; i < 4; i++)
            send(pat, 8'h03, 2'b01, 1'b0, 1'b1, 1'b0, 2'(i), 4'hF, "R8 R11 vl fault");
        for (int i = 0; i < 15; i += 5)
            send(pat, 8'h03, 2'b00, 1'b1, 1'b1, 1'b0, 2'b00, 4'(i), "R9 R11 vvvv fault");
        send(pat, 8'h02, 2'b11, 1'b0, 1'b1, 1'b1, 2'b00, 4'hF, "R10 R11 reserved size");
        send(pat, 8'h02, 2'b00, 1'b0, 1'b1, 1'b1, 2'b00, 4'hF, "R11 recover after fault");

        // Back-to-back requests.
        @(negedge clk);
        for (int i = 0; i < 4; i++) begin
            in_valid = 1'b1; in_src = pat; in_imm = 8'(i * 3); in_size = 2'b00;
            in_dst_mem = 1'b1; in_mode64 = 1'b1; in_wide = 1'b0; in_vl = 0; in_vvvv = 4'hF;
            sb_q.push_back(model(pat, 8'(i * 3), 2'b00, 1'b1, 1'b1, 1'b0, 2'b00, 4'hF, "R12 streaming"));
            @(negedge clk);
        end
        in_valid = 1'b0;
        repeat (3) @(negedge clk);
        check("R12 idle valid", {63'd0, out_valid}, 64'd0);
        check("R12 queue drained", 64'(sb_q.size()), 64'd0);

        send(pat, 8'h05, 2'b01, 1'b0, 1'b1, 1'b0, 2'b00, 4'hF, "R13 pre-reset");
        @(negedge clk);
        rst = 1'b1;
        @(negedge clk);
        check("R13 reset clears valid", {63'd0, out_valid}, 64'd0);
        rst = 1'b0;
        repeat (2) @(negedge clk);

        $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end
endmodule